// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the command interface of a serial flash memory model. It runs on one system clock. It samples the host's serial clock, chip select and data-in lines through synchronizers, and it shifts each opcode, address and data byte in most significant bit first on the serial clock's rising edges. The opcode decides what follows it: a three-byte address, one dummy byte, data bytes, or nothing at all. Read-type commands answer with a data-out stream that changes on the serial clock's falling edges. Commands that modify the array or the registers are staged while bytes arrive. They are committed through a single execute strobe when chip select returns high, but only if chip select rose on a byte boundary.

Data bytes of a modifying command stream out on `dat_valid`/`dat_byte` as each byte completes. The consumer stages them and acts on them only when `exec_stb` arrives. Neither stream has back-pressure: each byte and each strobe is valid for exactly one system clock, and the consumer must accept it in that cycle. The array supplies read bytes combinationally: `rd_data` must reflect `rd_addr` in the same cycle. While the array reports `busy`, every command except status read is ignored.

Top module: `spi_cmd_if`

## Requirements
- R1: Opcode, address and data bits are taken most significant bit first, one per rising serial clock edge while chip select is low. Address-bearing commands take a three-byte address that appears on `exec_addr`.
- R2: A modifying command executes only if its opcode and every address byte are complete. For example, a sector erase (0xD8) given one address byte is not executed.
- R3: Read (0x03) returns the array byte at the address, then the bytes at the following addresses, each MSB first. `miso` updates after falling serial clock edges and `miso_oe` is high during the data phase.
- R4: Fast read (0x0B) skips one dummy byte after the address before its data phase starts.
- R5: Status read (0x05) repeats `status_byte`, and lock read (0xE8, with an address) repeats `lock_byte`, for as long as the host clocks.
- R6: The modifying opcodes are 0x06, 0x04, 0x01, 0x0A, 0x02, 0xDB, 0x20, 0xD8, 0xC7, 0xB9, 0xAB and 0xE5. A complete modifying command gives `exec_stb` high for exactly one system clock after chip select rises. The strobe carries the opcode, the address and the data byte count.
- R7: If chip select rises when the bit count since it fell is not a multiple of eight, a modifying command gives no `exec_stb`.
- R8: A read command may be ended by chip select after any bit. The next command is then decoded normally.
- R9: While `busy` is high, no command executes, and reads other than status read drive nothing. Status read is still served.
- R10: An opcode outside the listed set gives no strobe and drives nothing until chip select rises.
- R11: After reset, and whenever chip select is high, `miso_oe` is low and `exec_stb` and `dat_valid` are idle.
- R12: Each complete data byte of a data-bearing modifying command (0x01, 0x0A, 0x02, 0xE5) pulses `dat_valid` with the byte. Such a command executes only if at least one data byte arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host (idles low) |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the `miso` pad; low means high impedance |
| busy | input | 1 | Array is running an internal write, program or erase cycle |
| rd_addr | output | ADDR_BYTES*8 | Array address of the next read byte |
| rd_data | input | 8 | Array byte at `rd_addr`, combinational |
| status_byte | input | 8 | Status register value |
| lock_byte | input | 8 | Lock register value |
| dat_valid | output | 1 | One-cycle pulse: a data byte completed |
| dat_byte | output | 8 | Data byte qualified by `dat_valid` |
| exec_stb | output | 1 | One-cycle execute strobe |
| exec_op | output | 8 | Opcode of the executed command |
| exec_addr | output | ADDR_BYTES*8 | Address of the executed command |
| exec_nbytes | output | clog2(PAGE_BYTES+1) | Data bytes received, saturating |

## Verification
The bit counter is the most fragile piece of state. If it is off by one, a correct command ending on a byte boundary loses its strobe, or a truncated one gains a strobe, within a few system clocks of chip select rising. The same fault makes every address and data byte arrive rotated. A wrong header length shows up at once in the read stream as a byte from the wrong address, or as a dummy byte that is not skipped. A busy or ignore flag stuck in the wrong state shows up as a strobe, or as an enabled data pin, during a command that should stay silent.

// File: rtl/spi_flash_pkg.sv
`timescale 1ns/1ps
package spi_flash_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_LOCK   = 2'd2
  } src_e;

  typedef struct packed {
    logic       valid;
    logic       is_mod;
    logic       is_read;
    logic [1:0] addr_n;
    logic       dummy;
    logic       has_data;
    src_e       src;
  } dec_t;

  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_RD        = 8'h03;
  localparam logic [7:0] OP_RD_FAST   = 8'h0B;
  localparam logic [7:0] OP_PG_WRITE  = 8'h0A;
  localparam logic [7:0] OP_PG_PROG   = 8'h02;
  localparam logic [7:0] OP_PG_ERASE  = 8'hDB;
  localparam logic [7:0] OP_SUB_ERASE = 8'h20;
  localparam logic [7:0] OP_SEC_ERASE = 8'hD8;
  localparam logic [7:0] OP_ALL_ERASE = 8'hC7;
  localparam logic [7:0] OP_SLEEP     = 8'hB9;
  localparam logic [7:0] OP_WAKE      = 8'hAB;
  localparam logic [7:0] OP_LOCK_WR   = 8'hE5;
  localparam logic [7:0] OP_LOCK_RD   = 8'hE8;

  // Per-opcode shape of the command: header bytes, direction, data source.
  function automatic dec_t decode(input logic [7:0] op);
    dec_t d;
    d = '0;
    d.src = SRC_ARRAY;
    case (op)
      OP_WR_EN, OP_WR_DIS, OP_ALL_ERASE, OP_SLEEP, OP_WAKE: begin
        d.valid = 1'b1; d.is_mod = 1'b1;
      end
      OP_STAT_WR: begin
        d.valid = 1'b1; d.is_mod = 1'b1; d.has_data = 1'b1;
      end
      OP_PG_WRITE, OP_PG_PROG, OP_LOCK_WR: begin
        d.valid = 1'b1; d.is_mod = 1'b1; d.has_data = 1'b1; d.addr_n = 2'd3;
      end
      OP_PG_ERASE, OP_SUB_ERASE, OP_SEC_ERASE: begin
        d.valid = 1'b1; d.is_mod = 1'b1; d.addr_n = 2'd3;
      end
      OP_STAT_RD: begin
        d.valid = 1'b1; d.is_read = 1'b1; d.src = SRC_STATUS;
      end
      OP_RD: begin
        d.valid = 1'b1; d.is_read = 1'b1; d.addr_n = 2'd3;
      end
      OP_RD_FAST: begin
        d.valid = 1'b1; d.is_read = 1'b1; d.addr_n = 2'd3; d.dummy = 1'b1;
      end
      OP_LOCK_RD: begin
        d.valid = 1'b1; d.is_read = 1'b1; d.addr_n = 2'd3; d.src = SRC_LOCK;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic is_modifying(input logic [7:0] op);
    dec_t d;
    d = decode(op);
    return d.is_mod;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
// Brings the host pins into the system clock domain and finds serial clock edges.
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic cs_hi,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_ch, cs_ch, mosi_ch;
  logic sclk_q, cs_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_ch <= '0; cs_ch <= '1; mosi_ch <= '0;
        end else begin
          sclk_ch <= sclk; cs_ch <= cs_n; mosi_ch <= mosi;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_ch <= '0; cs_ch <= '1; mosi_ch <= '0;
        end else begin
          sclk_ch <= {sclk_ch[STAGES-2:0], sclk};
          cs_ch   <= {cs_ch[STAGES-2:0], cs_n};
          mosi_ch <= {mosi_ch[STAGES-2:0], mosi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_ch[STAGES-1];
      cs_q   <= cs_ch[STAGES-1];
    end
  end

  assign cs_hi     = cs_ch[STAGES-1];
  assign cs_rise   = cs_ch[STAGES-1] & ~cs_q;
  assign sclk_rise = sclk_ch[STAGES-1] & ~sclk_q & ~cs_hi;
  assign sclk_fall = ~sclk_ch[STAGES-1] & sclk_q & ~cs_hi;
  assign mosi_s    = mosi_ch[STAGES-1];
endmodule

// File: rtl/spi_cmd_rx.sv
`timescale 1ns/1ps
// Input shifter, command decode, data byte stream and execute qualification.
module spi_cmd_rx
  import spi_flash_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DCNT_W     = 9,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  input  logic              busy,
  output logic              bit_zero,
  output logic              rd_active,
  output src_e              rd_src,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dat_valid,
  output logic [7:0]        dat_byte,
  output logic              exec_stb,
  output logic [7:0]        exec_op,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [DCNT_W-1:0] exec_nbytes
);
  logic [6:0]        sh;
  logic [2:0]        bit_cnt;
  logic [2:0]        byte_cnt;
  logic [7:0]        op_q;
  dec_t              dec_q;
  dec_t              dec_new;
  logic              ign;
  logic [DCNT_W-1:0] nb;
  logic [7:0]        b_full;
  logic [2:0]        hdr_len;
  logic              hdr_done;
  logic              exec_ok;

  assign b_full   = {sh, mosi_s};
  assign hdr_len  = 3'd1 + {1'b0, dec_q.addr_n} + {2'b00, dec_q.dummy};
  assign hdr_done = (byte_cnt >= hdr_len) && dec_q.valid;

  always_comb dec_new = decode(b_full);

  assign exec_ok = cs_rise && !ign && dec_q.is_mod && !busy && (bit_cnt == 3'd0)
                   && hdr_done && (!dec_q.has_data || nb != '0);

  assign bit_zero  = (bit_cnt == 3'd0);
  assign rd_active = hdr_done && dec_q.is_read && !ign;
  assign rd_src    = dec_q.src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      bit_cnt     <= '0;
      byte_cnt    <= '0;
      op_q        <= '0;
      dec_q       <= '0;
      ign         <= 1'b0;
      nb          <= '0;
      addr_q      <= '0;
      dat_valid   <= 1'b0;
      dat_byte    <= '0;
      exec_stb    <= 1'b0;
      exec_op     <= '0;
      exec_addr   <= '0;
      exec_nbytes <= '0;
    end else begin
      dat_valid <= 1'b0;
      exec_stb  <= 1'b0;
      if (exec_ok) begin
        exec_stb    <= 1'b1;
        exec_op     <= op_q;
        exec_addr   <= addr_q;
        exec_nbytes <= nb;
      end
      if (cs_hi) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ign      <= 1'b0;
        nb       <= '0;
        dec_q    <= '0;
      end else if (sclk_rise) begin
        sh      <= b_full[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
          if (byte_cnt == 3'd0) begin
            op_q  <= b_full;
            dec_q <= dec_new;
            ign   <= !dec_new.valid || (busy && b_full != OP_STAT_RD);
          end else if (byte_cnt <= {1'b0, dec_q.addr_n}) begin
            addr_q <= {addr_q[ADDR_W-9:0], b_full};
          end else if (hdr_done && dec_q.has_data && !ign) begin
            dat_valid <= 1'b1;
            dat_byte  <= b_full;
            if (nb != {DCNT_W{1'b1}}) nb <= nb + DCNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_rd_tx.sv
`timescale 1ns/1ps
// Output shifter: loads a byte at the start of each output byte slot, shifts on falling edges.
module spi_rd_tx
  import spi_flash_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              sclk_fall,
  input  logic              bit_zero,
  input  logic              rd_active,
  input  src_e              rd_src,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [7:0]        rd_data,
  input  logic [7:0]        status_byte,
  input  logic [7:0]        lock_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso,
  output logic              miso_oe
);
  logic [6:0]        sh;
  logic              first;
  logic [ADDR_W-1:0] cur;
  logic [7:0]        nxt;

  assign rd_addr = first ? hdr_addr : cur;

  always_comb begin
    case (rd_src)
      SRC_STATUS: nxt = status_byte;
      SRC_LOCK:   nxt = lock_byte;
      default:    nxt = rd_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      first   <= 1'b1;
      cur     <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (cs_hi) begin
      first   <= 1'b1;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (sclk_fall && rd_active) begin
      miso_oe <= 1'b1;
      if (bit_zero) begin
        miso  <= nxt[7];
        sh    <= nxt[6:0];
        cur   <= rd_addr + ADDR_W'(1);
        first <= 1'b0;
      end else begin
        miso <= sh[6];
        sh   <= {sh[5:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cmd_if.sv
`timescale 1ns/1ps
module spi_cmd_if
  import spi_flash_pkg::*;
#(
  parameter int ADDR_BYTES  = 3,
  parameter int PAGE_BYTES  = 256,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int DCNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic [7:0]        status_byte,
  input  logic [7:0]        lock_byte,
  output logic              dat_valid,
  output logic [7:0]        dat_byte,
  output logic              exec_stb,
  output logic [7:0]        exec_op,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [DCNT_W-1:0] exec_nbytes
);
  logic              cs_hi, cs_rise, sclk_rise, sclk_fall, mosi_s;
  logic              bit_zero, rd_active;
  src_e              rd_src;
  logic [ADDR_W-1:0] addr_q;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s)
  );

  spi_cmd_rx #(.ADDR_BYTES(ADDR_BYTES), .DCNT_W(DCNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .mosi_s(mosi_s), .busy(busy),
    .bit_zero(bit_zero), .rd_active(rd_active), .rd_src(rd_src), .addr_q(addr_q),
    .dat_valid(dat_valid), .dat_byte(dat_byte),
    .exec_stb(exec_stb), .exec_op(exec_op), .exec_addr(exec_addr),
    .exec_nbytes(exec_nbytes)
  );

  spi_rd_tx #(.ADDR_BYTES(ADDR_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sclk_fall(sclk_fall),
    .bit_zero(bit_zero), .rd_active(rd_active), .rd_src(rd_src),
    .hdr_addr(addr_q), .rd_data(rd_data), .status_byte(status_byte),
    .lock_byte(lock_byte), .rd_addr(rd_addr), .miso(miso), .miso_oe(miso_oe)
  );
endmodule

// File: rtl/spi_cmd_if_chk.sv
`timescale 1ns/1ps
module spi_cmd_if_chk
  import spi_flash_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_hi,
  input logic       busy,
  input logic       miso_oe,
  input logic       dat_valid,
  input logic       exec_stb,
  input logic [7:0] exec_op
);
  assert_exec_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> !exec_stb);

  assert_exec_mod_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> is_modifying(exec_op));

  assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> !$past(busy));

  assert_hiz_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && $past(cs_hi)) |-> !miso_oe);

  assert_dat_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !exec_stb);
endmodule

bind spi_cmd_if spi_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .busy(busy), .miso_oe(miso_oe),
  .dat_valid(dat_valid), .exec_stb(exec_stb), .exec_op(exec_op)
);

// File: tb/spi_cmd_if_bench.sv
`timescale 1ns/1ps
module spi_cmd_if_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic [7:0] status_byte = 8'hC3, lock_byte = 8'h7E;
  logic miso, miso_oe, dat_valid, exec_stb;
  logic [7:0] dat_byte, exec_op, rd_data;
  logic [23:0] rd_addr, exec_addr;
  logic [8:0] exec_nbytes;

  int n_chk = 0, n_fail = 0, ex_n = 0, dat_n = 0;
  logic [7:0] last_op;
  logic [23:0] last_addr;
  logic [8:0] last_nb;
  logic [7:0] dat_log [0:15];
  logic oe_seen;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  assign rd_data = rd_addr[7:0] ^ 8'h5A;

  spi_cmd_if u_spi_cmd_if (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .busy(busy), .rd_addr(rd_addr),
    .rd_data(rd_data), .status_byte(status_byte), .lock_byte(lock_byte),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .exec_stb(exec_stb),
    .exec_op(exec_op), .exec_addr(exec_addr), .exec_nbytes(exec_nbytes)
  );

  always @(negedge clk) begin
    if (exec_stb) begin
      ex_n <= ex_n + 1; last_op <= exec_op; last_addr <= exec_addr; last_nb <= exec_nbytes;
    end
    if (dat_valid) begin
      if (dat_n < 16) dat_log[dat_n] <= dat_byte;
      dat_n <= dat_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      oe_seen = oe_seen | miso_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic sel();
    oe_seen = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    byte_x(b, r);
  endtask

  task automatic t_reset();
    check(miso_oe == 1'b0, "R11 reset oe", miso_oe, 0);
    check(ex_n == 0 && dat_n == 0, "R11 reset idle", ex_n + dat_n, 0);
  endtask

  task automatic t_wren();
    int e0 = ex_n;
    sel(); send(8'h06); desel();
    check(ex_n == e0 + 1, "R6 write enable strobe", ex_n - e0, 1);
    check(last_op == 8'h06, "R6 opcode", last_op, 8'h06);
  endtask

  task automatic t_prog();
    int e0 = ex_n, d0 = dat_n;
    sel(); send(8'h02); send(8'h12); send(8'h34); send(8'h56); send(8'hA5); send(8'h3C); desel();
    check(ex_n == e0 + 1, "R6 program strobe", ex_n - e0, 1);
    check(last_addr == 24'h123456, "R1 address MSB first", last_addr, 24'h123456);
    check(last_nb == 9'd2, "R6 byte count", last_nb, 2);
    check(dat_n == d0 + 2 && dat_log[d0] == 8'hA5 && dat_log[d0+1] == 8'h3C, "R12 data stream",
          {dat_log[d0], dat_log[d0+1]}, 16'hA53C);
  endtask

  task automatic t_partial();
    int e0 = ex_n;
    logic [7:0] r;
    sel(); send(8'h06); bits(8'hFF, 3, r); desel();
    check(ex_n == e0, "R7 write enable plus 3 bits", ex_n - e0, 0);
    sel(); send(8'hD8); send(8'h00); send(8'h10); send(8'h00); bits(8'h00, 5, r); desel();
    check(ex_n == e0, "R7 erase plus 5 bits", ex_n - e0, 0);
  endtask

  task automatic t_header();
    int e0 = ex_n;
    sel(); send(8'hD8); send(8'h12); desel();
    check(ex_n == e0, "R2 short address", ex_n - e0, 0);
    sel(); send(8'hD8); send(8'hAB); send(8'hCD); send(8'hEF); desel();
    check(ex_n == e0 + 1 && last_addr == 24'hABCDEF, "R2 full erase", last_addr, 24'hABCDEF);
    sel(); send(8'h01); desel();
    check(ex_n == e0 + 1, "R12 status write without data", ex_n - e0, 1);
  endtask

  task automatic t_read();
    logic [7:0] r0, r1, r2;
    sel(); send(8'h03); send(8'h00); send(8'h01); send(8'hFE);
    check(oe_seen == 1'b0, "R3 silent in header", oe_seen, 0);
    byte_x(8'h00, r0); byte_x(8'h00, r1); byte_x(8'h00, r2);
    check(oe_seen == 1'b1, "R3 output enabled", oe_seen, 1);
    desel();
    check({r0, r1, r2} == 24'hA4A55A, "R3 read stream", {r0, r1, r2}, 24'hA4A55A);
  endtask

  task automatic t_fast();
    logic [7:0] r0, r1;
    sel(); send(8'h0B); send(8'h00); send(8'h00); send(8'h10); send(8'h00);
    check(oe_seen == 1'b0, "R4 dummy silent", oe_seen, 0);
    byte_x(8'h00, r0); byte_x(8'h00, r1); desel();
    check({r0, r1} == 16'h4A4B, "R4 fast read data", {r0, r1}, 16'h4A4B);
  endtask

  task automatic t_regs();
    logic [7:0] r0, r1;
    sel(); send(8'h05); byte_x(8'h00, r0); byte_x(8'h00, r1); desel();
    check(r0 == 8'hC3 && r1 == 8'hC3, "R5 status repeat", {r0, r1}, 16'hC3C3);
    sel(); send(8'hE8); send(8'h00); send(8'h20); send(8'h00); byte_x(8'h00, r0); desel();
    check(r0 == 8'h7E, "R5 lock read", r0, 8'h7E);
  endtask

  task automatic t_abort();
    int e0 = ex_n;
    logic [7:0] r;
    sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h00); bits(8'h00, 3, r);
    check(r[7:5] == 3'b010, "R8 partial read bits", r[7:5], 3'b010);
    desel();
    check(miso_oe == 1'b0, "R11 released after cs", miso_oe, 0);
    sel(); send(8'h04); desel();
    check(ex_n == e0 + 1 && last_op == 8'h04, "R8 next command decoded", last_op, 8'h04);
  endtask

  task automatic t_busy();
    int e0 = ex_n;
    logic [7:0] r;
    busy = 1'b1;
    sel(); send(8'hDB); send(8'h00); send(8'h01); send(8'h00); desel();
    check(ex_n == e0, "R9 erase while busy", ex_n - e0, 0);
    sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h00); byte_x(8'h00, r); desel();
    check(oe_seen == 1'b0, "R9 read while busy", oe_seen, 0);
    sel(); send(8'h05); byte_x(8'h00, r); desel();
    check(r == 8'hC3 && oe_seen, "R9 status while busy", r, 8'hC3);
    busy = 1'b0;
  endtask

  task automatic t_unknown();
    int e0 = ex_n;
    logic [7:0] r;
    sel(); send(8'h9F); byte_x(8'h00, r); byte_x(8'h00, r); desel();
    check(ex_n == e0 && oe_seen == 1'b0, "R10 unknown opcode", {ex_n - e0, 31'(oe_seen)}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wren();
    t_prog();
    t_partial();
    t_header();
    t_read();
    t_fast();
    t_regs();
    t_abort();
    t_busy();
    t_unknown();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule